// File: doc/BRIEF.md
# Multicycle Scheduled Update-Step Datapath

This block performs one step of a small numerical recurrence. From the primary inputs `x`, `y`, `u` and `dx` it forms `x1 = x + dx`, `y1 = y + u*dx` and `u1 = u - 3*dx*(x*u + y)`. It also raises a flag `cFlag` when `x1` is below a limit `aLim`. All values are 16-bit two's complement with wrap-around, and products are truncated to 16 bits.

The work is spread over a fixed schedule of eight compute cycles, sized for a 10 ns clock. Two multipliers each need three cycles, with their operands held stable. One single-cycle ALU performs the adds, the subtract and the compare. A constant shifter builds `3*dx` as `(dx << 1) + dx`, so no multiplier is spent on the constant. The product `3*dx` is formed once and multiplied by the factored sum `x*u + y`.

A controller waits for a `start` pulse in idle and steps through the schedule. It then raises `done` for one cycle, with every result valid. The inputs are not registered, so the user holds `x`, `y`, `u`, `dx` and `aLim` steady from `start` until `done`. Intermediate values share registers wherever their lifetimes do not overlap.

Top module: `poly_step_core`

## Requirements
- R1: While reset (`rstN` low) is applied and immediately after it, `done`, `cFlag`, `x1`, `y1` and `u1` are all 0.
- R2: `done` is never raised unless a `start` pulse was accepted, that is, sampled high on a rising edge while the block was idle.
- R3: `done` rises on the eighth rising edge after the edge that accepted `start`.
- R4: `done` stays high for exactly one cycle.
- R5: In the `done` cycle, `x1` equals `(x + dx) mod 2^16`.
- R6: In the `done` cycle, `y1` equals `(y + u*dx) mod 2^16`.
- R7: In the `done` cycle, `u1` equals `(u - 3*dx*(x*u + y)) mod 2^16`.
- R8: In the `done` cycle, `cFlag` is 1 exactly when the signed value of `x1` is strictly below the signed value of `aLim`. When `x1` equals `aLim`, `cFlag` is 0.
- R9: A `start` that arrives while a computation is running is ignored, and so is a `start` in the `done` cycle. Such a pulse neither restarts the schedule nor produces an extra `done`.
- R10: After `done`, `x1`, `y1`, `u1` and `cFlag` keep their values until the next accepted `start` has been followed by at least one more rising edge. This holds whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; accepted only while idle |
| x | input | 16 | Position operand |
| y | input | 16 | Offset operand |
| u | input | 16 | Rate operand |
| dx | input | 16 | Step operand |
| aLim | input | 16 | Signed compare limit |
| done | output | 1 | One-cycle completion strobe |
| x1 | output | 16 | Result x + dx |
| y1 | output | 16 | Result y + u*dx |
| u1 | output | 16 | Result u - 3*dx*(x*u + y) |
| cFlag | output | 1 | Signed x1 < aLim |

## Verification
The `done` strobe and a fresh `start` can fall in the same cycle. The design must not treat that pulse as a new request. The bench provokes this by raising `start` exactly in the cycle that `done` is high. It then requires that `done` drops on the next cycle, that no further `done` appears for twelve cycles, and that the results stay unchanged. A second case puts a `start` pulse mid-schedule, in the cycle where the ALU compare and the first multiplier capture coincide. That case is judged by an unchanged eight-edge latency and correct results.

// File: rtl/poly_pkg.sv
package poly_pkg;

  typedef enum logic [2:0] {
    ALU_X1,
    ALU_TRIPLE,
    ALU_CMP,
    ALU_SUM,
    ALU_Y1,
    ALU_U1
  } aluOp_e;

  typedef struct packed {
    logic   shEn;
    logic   aluEn;
    aluOp_e aluOp;
    logic   mulASel;
    logic   mulACap;
    logic   mulBCap;
  } ctrl_t;

endpackage

// File: rtl/poly_mul.sv
module poly_mul #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] prod
);
  // multicycle path: operands are held by the controller until capture
  assign prod = opA * opB;
endmodule

// File: rtl/poly_alu.sv
module poly_alu #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             sub,
  output logic [WIDTH-1:0] res,
  output logic             less
);
  assign res  = sub ? (opA - opB) : (opA + opB);
  assign less = $signed(opA) < $signed(opB);
endmodule

// File: rtl/poly_ctrl.sv
module poly_ctrl
  import poly_pkg::*;
#(
  parameter int MUL_CYC = 3
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  output logic  done,
  output ctrl_t ctrl
);
  localparam int LAT    = 2 * MUL_CYC + 2;
  localparam int STEP_W = $clog2(LAT + 1);
  localparam logic [STEP_W-1:0] S_FIRST  = STEP_W'(1);
  localparam logic [STEP_W-1:0] S_TRIPLE = STEP_W'(2);
  localparam logic [STEP_W-1:0] S_CMP    = STEP_W'(3);
  localparam logic [STEP_W-1:0] S_MULA1  = STEP_W'(MUL_CYC);
  localparam logic [STEP_W-1:0] S_SUM    = STEP_W'(MUL_CYC + 1);
  localparam logic [STEP_W-1:0] S_Y1     = STEP_W'(MUL_CYC + 2);
  localparam logic [STEP_W-1:0] S_MULA2  = STEP_W'(2 * MUL_CYC + 1);
  localparam logic [STEP_W-1:0] S_LAST   = STEP_W'(LAT);

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_FIN} phase_e;

  phase_e            phase;
  logic [STEP_W-1:0] step;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      step  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_RUN;
          step  <= S_FIRST;
        end
        PH_RUN: begin
          if (step == S_LAST) phase <= PH_FIN;
          else step <= step + STEP_W'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign done = (phase == PH_FIN);

  always_comb begin
    ctrl         = '0;
    ctrl.aluOp   = ALU_X1;
    ctrl.mulASel = (step > S_SUM);
    if (phase == PH_RUN) begin
      if (step == S_FIRST)  begin ctrl.shEn = 1'b1; ctrl.aluEn = 1'b1; ctrl.aluOp = ALU_X1; end
      if (step == S_TRIPLE) begin ctrl.aluEn = 1'b1; ctrl.aluOp = ALU_TRIPLE; end
      if (step == S_CMP)    begin ctrl.aluEn = 1'b1; ctrl.aluOp = ALU_CMP; end
      if (step == S_SUM)    begin ctrl.aluEn = 1'b1; ctrl.aluOp = ALU_SUM; end
      if (step == S_Y1)     begin ctrl.aluEn = 1'b1; ctrl.aluOp = ALU_Y1; end
      if (step == S_LAST)   begin ctrl.aluEn = 1'b1; ctrl.aluOp = ALU_U1; end
      if (step == S_MULA1)  begin ctrl.mulACap = 1'b1; ctrl.mulBCap = 1'b1; end
      if (step == S_MULA2)  ctrl.mulACap = 1'b1;
    end
  end
endmodule

// File: rtl/poly_dp.sv
module poly_dp
  import poly_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic [WIDTH-1:0] u,
  input  logic [WIDTH-1:0] dx,
  input  logic [WIDTH-1:0] aLim,
  output logic [WIDTH-1:0] x1,
  output logic [WIDTH-1:0] y1,
  output logic [WIDTH-1:0] u1,
  output logic             cFlag
);
  // regA: 2*dx then x*u+y | regB: 3*dx then u1 | regN: u*dx then y1
  logic [WIDTH-1:0] regA, regB, regX, regM, regN;
  logic             regC;
  logic [WIDTH-1:0] aluA, aluB, aluRes, mulAIn0, mulAIn1, prodA, prodB;
  logic             aluSub, aluLess;

  always_comb begin
    aluA   = x;
    aluB   = dx;
    aluSub = 1'b0;
    case (ctrl.aluOp)
      ALU_TRIPLE: begin aluA = regA; aluB = dx;   end
      ALU_CMP:    begin aluA = regX; aluB = aLim; end
      ALU_SUM:    begin aluA = regM; aluB = y;    end
      ALU_Y1:     begin aluA = y;    aluB = regN; end
      ALU_U1:     begin aluA = u;    aluB = regM; aluSub = 1'b1; end
      default:    begin aluA = x;    aluB = dx;   end
    endcase
  end

  assign mulAIn0 = ctrl.mulASel ? regA : x;
  assign mulAIn1 = ctrl.mulASel ? regB : u;

  poly_alu #(.WIDTH(WIDTH)) uAlu (
    .opA(aluA), .opB(aluB), .sub(aluSub), .res(aluRes), .less(aluLess)
  );

  poly_mul #(.WIDTH(WIDTH)) uMulA (.opA(mulAIn0), .opB(mulAIn1), .prod(prodA));
  poly_mul #(.WIDTH(WIDTH)) uMulB (.opA(u),       .opB(dx),      .prod(prodB));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
      regX <= '0;
      regM <= '0;
      regN <= '0;
      regC <= 1'b0;
    end else begin
      if (ctrl.shEn) regA <= dx << 1;
      if (ctrl.aluEn) begin
        case (ctrl.aluOp)
          ALU_X1:     regX <= aluRes;
          ALU_TRIPLE: regB <= aluRes;
          ALU_CMP:    regC <= aluLess;
          ALU_SUM:    regA <= aluRes;
          ALU_Y1:     regN <= aluRes;
          ALU_U1:     regB <= aluRes;
          default:    regX <= aluRes;
        endcase
      end
      if (ctrl.mulACap) regM <= prodA;
      if (ctrl.mulBCap) regN <= prodB;
    end
  end

  assign x1    = regX;
  assign y1    = regN;
  assign u1    = regB;
  assign cFlag = regC;
endmodule

// File: rtl/poly_step_core.sv
module poly_step_core
  import poly_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int MUL_CYC = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic [WIDTH-1:0] u,
  input  logic [WIDTH-1:0] dx,
  input  logic [WIDTH-1:0] aLim,
  output logic             done,
  output logic [WIDTH-1:0] x1,
  output logic [WIDTH-1:0] y1,
  output logic [WIDTH-1:0] u1,
  output logic             cFlag
);
  ctrl_t ctrl;

  poly_ctrl #(.MUL_CYC(MUL_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .done(done), .ctrl(ctrl)
  );

  poly_dp #(.WIDTH(WIDTH)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .x(x), .y(y), .u(u), .dx(dx), .aLim(aLim),
    .x1(x1), .y1(y1), .u1(u1), .cFlag(cFlag)
  );
endmodule

// File: rtl/poly_step_chk.sv
module poly_step_chk #(
  parameter int WIDTH   = 16,
  parameter int MUL_CYC = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [WIDTH-1:0] x,
  input logic [WIDTH-1:0] y,
  input logic [WIDTH-1:0] u,
  input logic [WIDTH-1:0] dx,
  input logic [WIDTH-1:0] aLim,
  input logic             done,
  input logic [WIDTH-1:0] x1,
  input logic [WIDTH-1:0] y1,
  input logic [WIDTH-1:0] u1,
  input logic             cFlag
);
  localparam int LAT = 2 * MUL_CYC + 2;
  localparam int CW  = $clog2(LAT + 2);

  logic          busyC;
  logic [CW-1:0] cnt;
  logic [WIDTH-1:0] expX1, expY1, expU1;

  initial begin
    sched_depth_chk: assert (MUL_CYC >= 3);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyC <= 1'b0;
      cnt   <= '0;
    end else if (!busyC) begin
      if (start) begin
        busyC <= 1'b1;
        cnt   <= '0;
      end
    end else if (done) begin
      busyC <= 1'b0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign expX1 = x + dx;
  assign expY1 = y + u * dx;
  assign expU1 = u - (WIDTH'(3) * dx) * (x * u + y);

  // R2
  idle_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyC |-> !done);

  // R3 R9
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cnt == CW'(LAT)));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  x1_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (x1 == expX1));

  // R6
  y1_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (y1 == expY1));

  // R7
  u1_poly_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (u1 == expU1));

  // R8
  cmp_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cFlag == ($signed(x1) < $signed(aLim))));

  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyC |=> ($stable(x1) && $stable(y1) && $stable(u1) && $stable(cFlag)));
endmodule

bind poly_step_core poly_step_chk #(.WIDTH(WIDTH), .MUL_CYC(MUL_CYC)) uChk (
  .clk(clk), .rstN(rstN), .start(start),
  .x(x), .y(y), .u(u), .dx(dx), .aLim(aLim),
  .done(done), .x1(x1), .y1(y1), .u1(u1), .cFlag(cFlag)
);

// File: tb/tb_poly_step_core.sv
`timescale 1ns/1ps
module tb_poly_step_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] x = '0, y = '0, u = '0, dx = '0, aLim = '0;
  logic        done, cFlag;
  logic [15:0] x1, y1, u1;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  poly_step_core dut (
    .clk(clk), .rstN(rstN), .start(start),
    .x(x), .y(y), .u(u), .dx(dx), .aLim(aLim),
    .done(done), .x1(x1), .y1(y1), .u1(u1), .cFlag(cFlag)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkReset();
    check(done == 1'b0,  "R1 done",  done,  0);
    check(x1 == 16'h0,   "R1 x1",    x1,    0);
    check(y1 == 16'h0,   "R1 y1",    y1,    0);
    check(u1 == 16'h0,   "R1 u1",    u1,    0);
    check(cFlag == 1'b0, "R1 cFlag", cFlag, 0);
  endtask

  // R2: nothing happens without a start
  task automatic checkNoSpontaneous();
    int seen = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (done) seen++;
    end
    check(seen == 0, "R2 no done without start", seen, 0);
  endtask

  // mode 0: plain run, mode 1: extra start mid-run, mode 2: start in done cycle
  task automatic runCase(input logic [15:0] vx, vy, vu, vdx, va, input int mode);
    logic [15:0] ex1, ey1, eu1;
    logic        ec;
    int          cnt;
    int          extra;
    ex1 = vx + vdx;
    ey1 = vy + vu * vdx;
    eu1 = vu - (16'd3 * vdx) * (vx * vu + vy);
    ec  = $signed(ex1) < $signed(va);
    @(negedge clk);
    x = vx; y = vy; u = vu; dx = vdx; aLim = va;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < 30) begin
      @(negedge clk);
      cnt++;
      start = (mode == 1 && cnt == 3);
    end
    start = 1'b0;
    check(cnt == 9, "R3 latency (R9 when restarted)", cnt, 9);
    check(x1 == ex1, "R5 x1", x1, ex1);
    check(y1 == ey1, "R6 y1", y1, ey1);
    check(u1 == eu1, "R7 u1", u1, eu1);
    check(cFlag == ec, "R8 cFlag", cFlag, ec);
    if (mode == 2) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R4 done single cycle", done, 0);
    if (mode != 0) begin
      extra = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, "R9 ignored start gives no done", extra, 0);
      check(u1 == eu1, "R9 u1 unchanged", u1, eu1);
    end
  endtask

  // R10: outputs hold while inputs move
  task automatic checkHold();
    logic [15:0] sx, sy, su;
    logic        sc;
    sx = x1; sy = y1; su = u1; sc = cFlag;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      x = x + 16'd77; y = y ^ 16'h5A5A; u = u - 16'd9; dx = dx + 16'd3; aLim = ~aLim;
    end
    @(negedge clk);
    check(x1 == sx, "R10 x1 held", x1, sx);
    check(y1 == sy, "R10 y1 held", y1, sy);
    check(u1 == su, "R10 u1 held", u1, su);
    check(cFlag == sc, "R10 cFlag held", cFlag, sc);
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    @(negedge clk);
    checkReset();
    checkNoSpontaneous();
    runCase(16'd5, 16'd7, 16'd2, 16'd3, 16'd100, 0);
    runCase(-16'sd20, -16'sd3, -16'sd4, 16'd6, -16'sd14, 0);  // R8 equal -> 0
    runCase(-16'sd20, -16'sd3, -16'sd4, 16'd6, -16'sd13, 0);  // R8 one above -> 1
    runCase(16'h7FFF, 16'h1234, 16'h4321, 16'd1, 16'd0, 0);   // wrap to negative
    runCase(16'hBEEF, 16'h0F0F, 16'h8001, 16'h7FFE, 16'h8000, 0);
    runCase(16'd1000, 16'd2000, 16'd300, 16'd45, 16'd1045, 1);
    runCase(16'd12, 16'hFFFF, 16'd9, 16'hFFF0, 16'd3, 2);
    checkHold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule